// File: doc/BRIEF.md
# Manual SPI Operation Sequencer

This block runs single-lane SPI flash transactions that software builds one step at a time. Software queues operation words, each an operation code with a byte count, into a small operation queue. It feeds transmit bytes into a byte-wide data queue and drains received bytes from the same queue. The engine takes operations from the queue in order. Depending on the code it sets the chip-select level, shifts bytes out of the data queue onto the serial line, or shifts bytes in and stores them for software.

The serial interface runs in SPI mode 0, most significant bit first. The serial clock is the system clock divided by two. A manual-enable input gates the engine. Manual mode turns on only when the enable is high and an external 4-bit read-machine state field is zero, which means that machine is idle. Once manual mode is on, that field no longer matters. When an output operation finds the data queue empty, or an input operation finds it full, the engine waits with the serial clock held low.

The state machine has six states:
- `ST_IDLE` takes the next operation. A chip-select code, an unknown code or a zero length finishes in that same cycle. A transmit code moves to `ST_TX_WAIT` and a receive code moves to `ST_RX_WAIT`.
- `ST_TX_WAIT` moves to `ST_TX_SHIFT` when a byte is available.
- `ST_TX_SHIFT` returns to `ST_TX_WAIT` after each byte, or to `ST_IDLE` after the last byte.
- `ST_RX_WAIT` moves to `ST_RX_SHIFT` when the queue has space.
- `ST_RX_SHIFT` moves to `ST_RX_STORE` once the byte has been shifted in.
- `ST_RX_STORE` stores the byte when there is space. It then goes back to `ST_RX_WAIT`, or to `ST_IDLE` after the last byte.

Top module: `spi_op_seq`

## Requirements
- R1: An operation word holds the byte count in bits [8:0] and the operation code in bits [13:9]. A pulse on `op_commit` queues `op_word`. `op_full` is high while OP_DEPTH words are queued, and a commit made while the queue is full is dropped.
- R2: Code 0x00 drives `spi_cs_n` low and code 0x01 drives it high, whatever the length field holds. The level holds through later operations until another chip-select code changes it. After reset `spi_cs_n` is high.
- R3: Code 0x08 sends the counted number of bytes, taken from the data queue in order, MSB first. Each bit lasts two system clocks with SCLK low for the first and high for the second. MOSI is stable when SCLK rises.
- R4: Code 0x0C receives the counted number of bytes, MSB first, sampling MISO while SCLK is high, and appends each byte to the data queue. MOSI stays low during reception.
- R5: `dat_rdata` shows the oldest byte in the data queue, and only a `dat_pop` pulse removes it. `dat_full` and `dat_empty` report the queue's fill state. A push into a full queue and a pop from an empty queue are ignored.
- R6: An output operation that finds the data queue empty holds SCLK low and waits for a byte. An input operation that finds the queue full waits until software pops a byte. No byte is lost in either case.
- R7: An operation with an unknown code, or a send or receive with count 0, produces no SCLK edge. It leaves chip select and the data queue unchanged.
- R8: `op_empty` is high only when the operation queue is empty and the last operation has finished on the pins.
- R9: Operations run only in manual mode. Manual mode turns on when `man_en` is 1 and `rd_fsm_state` is 0, and turns off when `man_en` is 0. While manual mode is on, `rd_fsm_state` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| man_en | input | 1 | Manual-mode request |
| rd_fsm_state | input | 4 | State of the memory-mapped read machine (0 = idle) |
| op_word | input | 14 | Operation word: code [13:9], byte count [8:0] |
| op_commit | input | 1 | Pulse that queues `op_word` |
| op_full | output | 1 | Operation queue full |
| op_empty | output | 1 | Operation queue empty and engine idle |
| dat_wdata | input | 8 | Byte for the data queue |
| dat_push | input | 1 | Pulse that queues `dat_wdata` |
| dat_pop | input | 1 | Pulse that removes the byte on `dat_rdata` |
| dat_rdata | output | 8 | Oldest byte in the data queue |
| dat_full | output | 1 | Data queue full |
| dat_empty | output | 1 | Data queue empty |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench builds the block with OP_DEPTH 4 and DAT_DEPTH 4. With these depths it sweeps every send and receive length up to a full data queue and fills the operation queue with a single short batch of commits. The small data depth lets a six-byte reception run into the full-queue stall after four bytes, and lets an oversize push sequence reach the dropped-write case. The slave model produces MISO bytes arithmetically from a seed and byte index, and records MOSI on every rising SCLK. Both directions are therefore compared against values computed in the bench.

// File: rtl/spi_op_seq_pkg.sv
package spi_op_seq_pkg;
    localparam int LEN_W  = 9;
    localparam int CODE_W = 5;
    localparam int OP_W   = LEN_W + CODE_W;
    localparam int BYTE_W = 8;
    localparam int RST_W  = 4;

    localparam logic [CODE_W-1:0] OPC_CS_LOW  = 5'h00;
    localparam logic [CODE_W-1:0] OPC_CS_HIGH = 5'h01;
    localparam logic [CODE_W-1:0] OPC_SEND    = 5'h08;
    localparam logic [CODE_W-1:0] OPC_RECV    = 5'h0C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_WAIT,
        ST_TX_SHIFT,
        ST_RX_WAIT,
        ST_RX_SHIFT,
        ST_RX_STORE
    } seq_state_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [LEN_W-1:0]  len;
    } op_word_t;
endpackage

// File: rtl/spi_op_seq_fifo.sv
module spi_op_seq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_wr, do_rd;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wp] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) begin
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            end
            if (do_rd) begin
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            end
            if (do_wr && !do_rd) begin
                cnt <= cnt + CW'(1);
            end else if (do_rd && !do_wr) begin
                cnt <= cnt - CW'(1);
            end
        end
    end
endmodule

// File: rtl/spi_op_seq_shift.sv
module spi_op_seq_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] tx_byte,
    input  logic         miso,
    output logic         done,
    output logic [W-1:0] rx_byte,
    output logic         sclk,
    output logic         mosi
);
    localparam int NB = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  sreg;
    logic [NB-1:0] nbit;
    logic          busy_q, sclk_q, done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg   <= '0;
            nbit   <= '0;
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    sreg   <= tx_byte;
                    nbit   <= '0;
                    sclk_q <= 1'b0;
                end
            end else if (!sclk_q) begin
                sclk_q <= 1'b1;
            end else begin
                sclk_q <= 1'b0;
                sreg   <= {sreg[W-2:0], miso};
                nbit   <= nbit + NB'(1);
                if (nbit == NB'(W - 1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = busy_q & sreg[W-1];
    assign done    = done_q;
    assign rx_byte = sreg;
endmodule

// File: rtl/spi_op_seq.sv
module spi_op_seq
    import spi_op_seq_pkg::*;
#(
    parameter int OP_DEPTH  = 4,
    parameter int DAT_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              man_en,
    input  logic [RST_W-1:0]  rd_fsm_state,
    input  logic [OP_W-1:0]   op_word,
    input  logic              op_commit,
    output logic              op_full,
    output logic              op_empty,
    input  logic [BYTE_W-1:0] dat_wdata,
    input  logic              dat_push,
    input  logic              dat_pop,
    output logic [BYTE_W-1:0] dat_rdata,
    output logic              dat_full,
    output logic              dat_empty,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    seq_state_t        state, nxt;
    logic [OP_W-1:0]   op_head;
    op_word_t          head;
    logic              opq_empty, op_pop;
    logic              eng_push, eng_pop;
    logic              sh_start, sh_done;
    logic [BYTE_W-1:0] sh_tx, sh_rx;
    logic              active;
    logic              cs_q, cs_set, cs_val;
    logic [LEN_W-1:0]  rem;
    logic              rem_load, rem_dec;

    spi_op_seq_fifo #(.W(OP_W), .DEPTH(OP_DEPTH)) u_opq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(op_commit), .wr_data(op_word),
        .rd_en(op_pop), .rd_data(op_head),
        .full(op_full), .empty(opq_empty)
    );

    // engine strobes win over coincident software strobes
    spi_op_seq_fifo #(.W(BYTE_W), .DEPTH(DAT_DEPTH)) u_datq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(eng_push | dat_push), .wr_data(eng_push ? sh_rx : dat_wdata),
        .rd_en(eng_pop | dat_pop), .rd_data(dat_rdata),
        .full(dat_full), .empty(dat_empty)
    );

    spi_op_seq_shift #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start(sh_start), .tx_byte(sh_tx), .miso(spi_miso),
        .done(sh_done), .rx_byte(sh_rx),
        .sclk(spi_sclk), .mosi(spi_mosi)
    );

    assign head = op_word_t'(op_head);

    // manual-mode gate (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (!man_en) begin
            active <= 1'b0;
        end else if (!active && rd_fsm_state == '0) begin
            active <= 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state and control outputs
    always_comb begin
        nxt      = state;
        op_pop   = 1'b0;
        eng_push = 1'b0;
        eng_pop  = 1'b0;
        sh_start = 1'b0;
        sh_tx    = '0;
        cs_set   = 1'b0;
        cs_val   = 1'b1;
        rem_load = 1'b0;
        rem_dec  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (active && !opq_empty) begin
                    op_pop = 1'b1;
                    case (head.code)
                        OPC_CS_LOW: begin
                            cs_set = 1'b1;
                            cs_val = 1'b0;
                        end
                        OPC_CS_HIGH: begin
                            cs_set = 1'b1;
                            cs_val = 1'b1;
                        end
                        OPC_SEND: begin
                            if (head.len != '0) begin
                                rem_load = 1'b1;
                                nxt      = ST_TX_WAIT;
                            end
                        end
                        OPC_RECV: begin
                            if (head.len != '0) begin
                                rem_load = 1'b1;
                                nxt      = ST_RX_WAIT;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_TX_WAIT: begin
                if (!dat_empty) begin
                    eng_pop  = 1'b1;
                    sh_start = 1'b1;
                    sh_tx    = dat_rdata;
                    nxt      = ST_TX_SHIFT;
                end
            end
            ST_TX_SHIFT: begin
                if (sh_done) begin
                    rem_dec = 1'b1;
                    nxt     = (rem == LEN_W'(1)) ? ST_IDLE : ST_TX_WAIT;
                end
            end
            ST_RX_WAIT: begin
                if (!dat_full) begin
                    sh_start = 1'b1;
                    nxt      = ST_RX_SHIFT;
                end
            end
            ST_RX_SHIFT: begin
                if (sh_done) begin
                    nxt = ST_RX_STORE;
                end
            end
            ST_RX_STORE: begin
                if (!dat_full) begin
                    eng_push = 1'b1;
                    rem_dec  = 1'b1;
                    nxt      = (rem == LEN_W'(1)) ? ST_IDLE : ST_RX_WAIT;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= 1'b1;
            rem  <= '0;
        end else begin
            if (cs_set) begin
                cs_q <= cs_val;
            end
            if (rem_load) begin
                rem <= head.len;
            end else if (rem_dec) begin
                rem <= rem - LEN_W'(1);
            end
        end
    end

    assign spi_cs_n = cs_q;
    assign op_empty = opq_empty && (state == ST_IDLE);
endmodule

// File: rtl/spi_op_seq_chk.sv
module spi_op_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic op_full,
    input logic op_empty,
    input logic dat_full,
    input logic dat_empty
);
    // R3: data is settled before the rising clock edge
    a_r3_mosi_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> $stable(spi_mosi));

    // R3: high phase lasts one system clock
    a_r3_sclk_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |=> !spi_sclk);

    // R8: no clocking once all work has finished
    a_r8_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        op_empty |-> !spi_sclk);

    // R1: operation queue cannot be full and drained at once
    a_r1_op_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_full && op_empty));

    // R5: data queue flags are exclusive
    a_r5_dat_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_full && dat_empty));
endmodule

bind spi_op_seq spi_op_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .op_full(op_full), .op_empty(op_empty),
    .dat_full(dat_full), .dat_empty(dat_empty)
);

// File: tb/spi_op_seq_test.sv
module spi_op_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        man_en = 1'b0;
    logic [3:0]  rd_fsm_state = 4'h0;
    logic [13:0] op_word = '0;
    logic        op_commit = 1'b0;
    logic        op_full, op_empty;
    logic [7:0]  dat_wdata = '0;
    logic        dat_push = 1'b0;
    logic        dat_pop = 1'b0;
    logic [7:0]  dat_rdata;
    logic        dat_full, dat_empty;
    logic        spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_op_seq #(.OP_DEPTH(4), .DAT_DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .man_en(man_en), .rd_fsm_state(rd_fsm_state),
        .op_word(op_word), .op_commit(op_commit), .op_full(op_full), .op_empty(op_empty),
        .dat_wdata(dat_wdata), .dat_push(dat_push), .dat_pop(dat_pop),
        .dat_rdata(dat_rdata), .dat_full(dat_full), .dat_empty(dat_empty),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- slave model ----------------
    int         seed = 0;
    int         sk = 0;
    logic       cs_seen = 1'b1;
    int         cyc = 0;
    int         nbits = 0;
    int         last_rise = 0;
    int         bad_period = 0;
    logic [7:0] cap = '0;
    logic [7:0] slog [512];

    function automatic logic [7:0] pat(input int s, input int j);
        return 8'((j * 53 + s) & 255);
    endfunction

    function automatic logic pbit(input int s, input int k);
        logic [7:0] v;
        v = pat(s, k >> 3);
        return v[7 - (k & 7)];
    endfunction

    always @(posedge clk) cyc = cyc + 1;

    always @(negedge spi_sclk or spi_cs_n) begin
        #1;
        if (cs_seen != spi_cs_n) begin
            cs_seen = spi_cs_n;
            if (!spi_cs_n) sk = 0;
        end else begin
            sk = sk + 1;
        end
        spi_miso = pbit(seed, sk);
    end

    always @(posedge spi_sclk) begin
        cap   = {cap[6:0], spi_mosi};
        nbits = nbits + 1;
        if ((nbits % 8) != 1 && (cyc - last_rise) != 2) bad_period = bad_period + 1;
        last_rise = cyc;
        if ((nbits % 8) == 0) slog[((nbits / 8) - 1) % 512] = cap;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic commit(input logic [4:0] code, input logic [8:0] len);
        @(negedge clk);
        op_word   = {code, len};
        op_commit = 1'b1;
        @(negedge clk);
        op_commit = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        dat_wdata = b;
        dat_push  = 1'b1;
        @(negedge clk);
        dat_push  = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        dat_pop = 1'b1;
        @(negedge clk);
        dat_pop = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        @(negedge clk);
        while (!op_empty && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) chk("R8 op_empty timeout", 0, 1);
    endtask

    function automatic logic [7:0] txb(input int len, input int i);
        return 8'((len * 29 + i * 71 + 3) & 255);
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int base;
        logic [7:0] edge_vals [4];
        edge_vals[0] = 8'h00; edge_vals[1] = 8'hFF;
        edge_vals[2] = 8'h80; edge_vals[3] = 8'h01;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset cs_n", spi_cs_n, 1);
        chk("R3 reset sclk", spi_sclk, 0);
        chk("R8 reset op_empty", op_empty, 1);
        chk("R1 reset op_full", op_full, 0);
        chk("R5 reset dat_empty", dat_empty, 1);
        chk("R5 reset dat_full", dat_full, 0);

        // R1 / R9: fill queue while manual mode is off
        commit(5'h00, 9'd1);
        commit(5'h01, 9'd1);
        commit(5'h00, 9'd1);
        commit(5'h1F, 9'd3);
        chk("R1 op_full after depth commits", op_full, 1);
        commit(5'h01, 9'd1);
        repeat (10) @(negedge clk);
        chk("R9 no execution while off", spi_cs_n, 1);
        chk("R9 queue held while off", op_empty, 0);
        man_en = 1'b1;
        rd_fsm_state = 4'h6;
        repeat (10) @(negedge clk);
        chk("R9 blocked by busy read machine", spi_cs_n, 1);
        rd_fsm_state = 4'h0;
        wait_done();
        chk("R1 overflow commit dropped", spi_cs_n, 0);
        chk("R7 unknown op no clock", nbits, 0);
        rd_fsm_state = 4'h9;

        // R3: transmit length sweep
        for (int len = 1; len <= 4; len++) begin
            base = nbits;
            for (int i = 0; i < len; i++) push(txb(len, i));
            commit(5'h08, 9'(len));
            repeat (4) @(negedge clk);
            chk("R8 busy during send", op_empty, 0);
            wait_done();
            chk("R3 bit count", nbits - base, 8 * len);
            for (int i = 0; i < len; i++)
                chk("R3 sent byte", slog[(base / 8 + i) % 512], txb(len, i));
            chk("R3 data queue drained", dat_empty, 1);
        end
        base = nbits;
        for (int i = 0; i < 4; i++) push(edge_vals[i]);
        commit(5'h08, 9'd4);
        wait_done();
        for (int i = 0; i < 4; i++)
            chk("R3 edge pattern", slog[(base / 8 + i) % 512], edge_vals[i]);
        chk("R3 bit period", bad_period, 0);

        // R4: receive length sweep
        for (int len = 1; len <= 4; len++) begin
            seed = 16 * len + 7;
            commit(5'h01, 9'd1);
            commit(5'h00, 9'd1);
            base = nbits;
            commit(5'h0C, 9'(len));
            wait_done();
            chk("R4 full flag", dat_full, (len == 4) ? 1 : 0);
            for (int i = 0; i < len; i++) begin
                chk("R4 received byte", dat_rdata, pat(seed, i));
                chk("R4 mosi low", slog[(base / 8 + i) % 512], 0);
                pop();
            end
            chk("R4 queue empty after pops", dat_empty, 1);
        end

        // R6: send stall
        base = nbits;
        push(8'h3C);
        commit(5'h08, 9'd2);
        repeat (60) @(negedge clk);
        chk("R6 send stalled", op_empty, 0);
        chk("R6 first byte only", nbits - base, 8);
        repeat (20) @(negedge clk);
        chk("R6 no clock while stalled", nbits - base, 8);
        push(8'hC3);
        wait_done();
        chk("R6 stalled byte 0", slog[(base / 8) % 512], 8'h3C);
        chk("R6 stalled byte 1", slog[(base / 8 + 1) % 512], 8'hC3);

        // R6: receive stall
        seed = 101;
        commit(5'h01, 9'd1);
        commit(5'h00, 9'd1);
        base = nbits;
        commit(5'h0C, 9'd6);
        repeat (150) @(negedge clk);
        chk("R6 receive full", dat_full, 1);
        chk("R6 receive stalled", op_empty, 0);
        chk("R6 receive bits held", nbits - base, 32);
        for (int i = 0; i < 2; i++) begin
            chk("R6 rx early byte", dat_rdata, pat(seed, i));
            pop();
        end
        wait_done();
        for (int i = 2; i < 6; i++) begin
            chk("R6 rx late byte", dat_rdata, pat(seed, i));
            pop();
        end

        // R7: discarded operations
        push(8'h5A);
        base = nbits;
        commit(5'h05, 9'd3);
        commit(5'h08, 9'd0);
        commit(5'h0C, 9'd0);
        wait_done();
        chk("R7 no clock", nbits - base, 0);
        chk("R7 queue kept", dat_empty, 0);
        chk("R7 byte kept", dat_rdata, 8'h5A);
        chk("R7 cs kept", spi_cs_n, 0);
        pop();

        // R5: queue behaviour
        pop();
        chk("R5 pop on empty ignored", dat_empty, 1);
        for (int i = 0; i < 5; i++) push(8'(i * 17 + 2));
        chk("R5 full", dat_full, 1);
        for (int i = 0; i < 4; i++) begin
            chk("R5 order", dat_rdata, 8'(i * 17 + 2));
            pop();
        end
        chk("R5 extra push dropped", dat_empty, 1);

        // R9: leaving and re-entering manual mode
        man_en = 1'b0;
        commit(5'h01, 9'd1);
        repeat (10) @(negedge clk);
        chk("R9 off holds cs", spi_cs_n, 0);
        chk("R9 off holds queue", op_empty, 0);
        man_en = 1'b1;
        repeat (10) @(negedge clk);
        chk("R9 re-entry blocked", spi_cs_n, 0);
        rd_fsm_state = 4'h0;
        wait_done();
        chk("R2 cs high after re-entry", spi_cs_n, 1);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule